// File: doc/BRIEF.md
# Synchronous Serial Port Master with Busy Flow Control

This block is a clocked serial master that exchanges one word at a time with a partner over a serial clock, a serial output and a serial input. A word is either 16 bits or 8 bits wide, chosen per transfer by a width input. The serial clock comes from a divider of the system clock whose setting gives the length of each clock half-period. A busy line shows the partner, and the local logic, that a transfer is in progress.

A transfer starts with a single-cycle start strobe. The strobe also captures the word to send, the width and the divider setting. When the last bit has been received, the block presents the received word together with a one-cycle done pulse, and busy drops in the same cycle. A start strobe that arrives while the port is busy is dropped and sets a collision flag, which stays set until reset.

Top module: `sport_master`

## Requirements
- R1: While reset is high and in the first cycle after it, sclk_o is 1, and busy_o, done_o, collide_o and rx_word_o are all 0.
- R2: With wide_i=1 at start, 16 bits of tx_word_i are sent most significant bit first. The 16 bits received are returned in rx_word_o[15:0], with the first bit received in bit 15.
- R3: With wide_i=0 at start, only tx_word_i[7:0] is sent, starting with bit 7, and tx_word_i[15:8] has no effect. Exactly 8 clock pulses occur. rx_word_o[7:0] holds the 8 bits received, the first one in bit 7, and rx_word_o[15:8] is 0.
- R4: Each low phase and each high phase of sclk_o lasts H system cycles, where H is the value of div_i captured at start, raised to 4 if it is smaller. The full period is therefore never shorter than 8 cycles.
- R5: sdo_o changes only where sclk_o falls, which includes the first fall at start. sdi_i is sampled where sclk_o rises.
- R6: busy_o goes high in the cycle after an accepted start and stays high for exactly 2*H*N+1 cycles, where N is 8 or 16. It falls H+1 cycles after the last rising edge of sclk_o. sclk_o is low only while busy_o is high.
- R7: done_o is a one-cycle pulse in the cycle in which busy_o falls. rx_word_o takes the received word in that same cycle and keeps it until the next done_o.
- R8: A start_i seen while busy_o is high has no effect on the transfer in progress and produces no extra done_o. It sets collide_o, which stays 1 until reset.
- R9: sclk_o is 1 whenever busy_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start strobe for one transfer |
| wide_i | input | 1 | Word width at start: 1 = 16 bits, 0 = 8 bits |
| div_i | input | DIV_W | Half-period of the serial clock in system cycles (minimum 4) |
| tx_word_i | input | 16 | Word to send, captured at start |
| sdi_i | input | 1 | Serial data from the partner |
| sclk_o | output | 1 | Serial clock, idles high |
| sdo_o | output | 1 | Serial data to the partner |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle pulse when the received word is valid |
| rx_word_o | output | 16 | Last received word |
| collide_o | output | 1 | Sticky flag: a start was seen while busy |

## Verification
The bench builds the block with DIV_W=5, so divider settings reach 31. It runs settings of 0 and 3, which are clamped to 4, the exact minimum of 4, and mid and top values of 7 and 31. Because the divider is narrow, even a 16-bit word at the largest setting finishes within about a thousand cycles. This allows exact counts of phase lengths and busy time in both word widths, and a start strobe can be placed partway through a transfer to test collisions.

// File: rtl/sport_pkg.sv
package sport_pkg;

    localparam int WORD_W   = 16;
    localparam int NARROW_W = 8;
    localparam int MIN_HALF = 4;
    localparam int BIT_CW   = $clog2(WORD_W);

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOW,
        ST_HIGH,
        ST_FINISH
    } sp_state_e;

    function automatic logic [BIT_CW-1:0] last_index(input logic wide);
        return wide ? BIT_CW'(WORD_W - 1) : BIT_CW'(NARROW_W - 1);
    endfunction

endpackage

// File: rtl/sport_halfgen.sv
module sport_halfgen
    import sport_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic             run_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);
    localparam int HW = (DIV_W > 3) ? DIV_W : 3;

    logic [HW-1:0] div_x;
    logic [HW-1:0] half_new;
    logic [HW-1:0] half_q;
    logic [HW-1:0] cnt_q;

    assign div_x    = HW'(div_i);
    assign half_new = (div_x < HW'(MIN_HALF)) ? HW'(MIN_HALF) : div_x;

    always_ff @(posedge clk) begin
        if (rst) begin
            half_q <= HW'(MIN_HALF);
            cnt_q  <= '0;
        end else if (load_i) begin
            half_q <= half_new;
            cnt_q  <= half_new - HW'(1);
        end else if (run_i) begin
            if (cnt_q == '0)
                cnt_q <= half_q - HW'(1);
            else
                cnt_q <= cnt_q - HW'(1);
        end
    end

    assign tick_o = run_i && (cnt_q == '0);

endmodule

// File: rtl/sport_shift.sv
module sport_shift
    import sport_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  logic              wide_i,
    input  logic [WORD_W-1:0] tx_i,
    input  logic              advance_i,
    input  logic              sample_i,
    input  logic              sdi_i,
    output logic              sdo_o,
    output logic [WORD_W-1:0] rx_o
);
    logic [WORD_W-1:0] tx_q;
    logic [WORD_W-1:0] rx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_q <= '0;
            rx_q <= '0;
        end else begin
            if (load_i)
                tx_q <= wide_i ? tx_i
                               : {tx_i[NARROW_W-1:0], {(WORD_W-NARROW_W){1'b0}}};
            else if (advance_i)
                tx_q <= {tx_q[WORD_W-2:0], 1'b0};

            if (load_i)
                rx_q <= '0;
            else if (sample_i)
                rx_q <= {rx_q[WORD_W-2:0], sdi_i};
        end
    end

    assign sdo_o = tx_q[WORD_W-1];
    assign rx_o  = rx_q;

endmodule

// File: rtl/sport_master.sv
module sport_master
    import sport_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              wide_i,
    input  logic [DIV_W-1:0]  div_i,
    input  logic [WORD_W-1:0] tx_word_i,
    input  logic              sdi_i,
    output logic              sclk_o,
    output logic              sdo_o,
    output logic              busy_o,
    output logic              done_o,
    output logic [WORD_W-1:0] rx_word_o,
    output logic              collide_o
);
    sp_state_e         state_q;
    logic [BIT_CW-1:0] bits_q;
    logic              sclk_q;
    logic              done_q;
    logic              coll_q;
    logic [WORD_W-1:0] rxo_q;
    logic [WORD_W-1:0] rx_live;

    logic accept;
    logic run;
    logic tick;
    logic sample;
    logic advance;

    assign busy_o  = (state_q != ST_IDLE);
    assign accept  = start_i && !busy_o;
    assign run     = (state_q == ST_LOW) || (state_q == ST_HIGH);
    assign sample  = (state_q == ST_LOW) && tick;
    assign advance = (state_q == ST_HIGH) && tick && (bits_q != '0);

    sport_halfgen #(.DIV_W(DIV_W)) u_half (
        .clk    (clk),
        .rst    (rst),
        .load_i (accept),
        .run_i  (run),
        .div_i  (div_i),
        .tick_o (tick)
    );

    sport_shift u_shift (
        .clk       (clk),
        .rst       (rst),
        .load_i    (accept),
        .wide_i    (wide_i),
        .tx_i      (tx_word_i),
        .advance_i (advance),
        .sample_i  (sample),
        .sdi_i     (sdi_i),
        .sdo_o     (sdo_o),
        .rx_o      (rx_live)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            bits_q  <= '0;
            sclk_q  <= 1'b1;
            done_q  <= 1'b0;
            coll_q  <= 1'b0;
            rxo_q   <= '0;
        end else begin
            done_q <= 1'b0;
            if (start_i && busy_o)
                coll_q <= 1'b1;
            unique case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        state_q <= ST_LOW;
                        sclk_q  <= 1'b0;
                        bits_q  <= last_index(wide_i);
                    end
                end
                ST_LOW: begin
                    if (tick) begin
                        sclk_q  <= 1'b1;
                        state_q <= ST_HIGH;
                    end
                end
                ST_HIGH: begin
                    if (tick) begin
                        if (bits_q == '0) begin
                            state_q <= ST_FINISH;
                        end else begin
                            sclk_q  <= 1'b0;
                            bits_q  <= bits_q - BIT_CW'(1);
                            state_q <= ST_LOW;
                        end
                    end
                end
                ST_FINISH: begin
                    state_q <= ST_IDLE;
                    done_q  <= 1'b1;
                    rxo_q   <= rx_live;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign sclk_o    = sclk_q;
    assign done_o    = done_q;
    assign collide_o = coll_q;
    assign rx_word_o = rxo_q;

endmodule

// File: rtl/sport_master_chk.sv
module sport_master_chk
    import sport_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input logic clk,
    input logic rst,
    input logic sclk_o,
    input logic sdo_o,
    input logic busy_o,
    input logic done_o,
    input logic collide_o
);
    localparam int LR_W = DIV_W + 2;

    logic [LR_W-1:0] lowrun;

    always_ff @(posedge clk) begin
        if (rst)
            lowrun <= '0;
        else if (!sclk_o) begin
            if (lowrun != {LR_W{1'b1}})
                lowrun <= lowrun + LR_W'(1);
        end else
            lowrun <= '0;
    end

    AST_IDLE_SCLK_HIGH: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> sclk_o); // R9

    AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (!busy_o && $past(busy_o))); // R7

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o); // R7

    AST_SDO_HOLD_HIGH: assert property (@(posedge clk) disable iff (rst)
        (sclk_o && $past(sclk_o)) |-> $stable(sdo_o)); // R5

    AST_MIN_LOW_PHASE: assert property (@(posedge clk) disable iff (rst)
        $rose(sclk_o) |-> (lowrun >= LR_W'(MIN_HALF))); // R4

    AST_CLK_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst)
        !sclk_o |-> busy_o); // R6

    AST_COLLIDE_STICKY: assert property (@(posedge clk) disable iff (rst)
        $past(collide_o) |-> collide_o); // R8

endmodule

bind sport_master sport_master_chk #(.DIV_W(DIV_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .sclk_o    (sclk_o),
    .sdo_o     (sdo_o),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .collide_o (collide_o)
);

// File: tb/sport_master_tb.sv
module sport_master_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DIV_W      = 5;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start_i = 1'b0;
    logic              wide_i = 1'b0;
    logic [DIV_W-1:0]  div_i = '0;
    logic [15:0]       tx_word_i = '0;
    logic              sdi_i = 1'b0;
    logic              sclk_o, sdo_o, busy_o, done_o, collide_o;
    logic [15:0]       rx_word_o;

    sport_master #(.DIV_W(DIV_W)) u_dut (
        .clk(clk), .rst(rst), .start_i(start_i), .wide_i(wide_i),
        .div_i(div_i), .tx_word_i(tx_word_i), .sdi_i(sdi_i),
        .sclk_o(sclk_o), .sdo_o(sdo_o), .busy_o(busy_o), .done_o(done_o),
        .rx_word_o(rx_word_o), .collide_o(collide_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {
        logic [15:0] rx;
        logic [15:0] tx;
        int          half;
        int          nbits;
    } exp_t;

    exp_t exp_q[$];

    int total = 0;
    int fails = 0;
    int done_cnt = 0;

    // slave model and monitor state
    logic [15:0] slv_sh = '0;
    logic [15:0] cap = '0;
    logic        sclk_prev = 1'b1;
    logic        sdo_prev = 1'b0;
    int          cur_half = 4;
    int          bits_seen = 0;
    int          lowrun = 0;
    int          highrun = 0;
    int          busy_run = 0;
    bit          phase_bad = 0;
    bit          sdo_bad = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // monitor and slave, all at the falling system clock edge
    always @(negedge clk) begin
        if (!rst) begin
            if (busy_o) busy_run++;
            if (sclk_prev && !sclk_o) begin
                if (bits_seen > 0 && highrun != cur_half) phase_bad = 1;
                lowrun  = 1;
                sdi_i   <= slv_sh[15];
                slv_sh  = {slv_sh[14:0], 1'b0};
            end else if (!sclk_prev && sclk_o) begin
                if (lowrun != cur_half) phase_bad = 1;
                highrun = 1;
                bits_seen++;
                cap = {cap[14:0], sdo_o};
            end else if (!sclk_o) begin
                lowrun++;
            end else begin
                highrun++;
                if (sclk_prev && busy_o && sdo_o != sdo_prev) sdo_bad = 1;
            end
            if (done_o) begin
                if (exp_q.size() == 0) begin
                    chk(0, "R8", "unexpected done", 1, 0);
                end else begin
                    exp_t e;
                    string rq;
                    e  = exp_q.pop_front();
                    rq = (e.nbits == 16) ? "R2" : "R3";
                    chk(rx_word_o == e.rx, rq, "received word", rx_word_o, e.rx);
                    chk(cap == e.tx, rq, "sent bits", cap, e.tx);
                    chk(bits_seen == e.nbits, rq, "clock pulses", bits_seen, e.nbits);
                    chk(!phase_bad, "R4", "phase length", 1, 0);
                    chk(!sdo_bad, "R5", "sdo moved while clock high", 1, 0);
                    chk(busy_run == 2*e.half*e.nbits + 1, "R6", "busy cycles",
                        busy_run, 2*e.half*e.nbits + 1);
                    chk(!busy_o, "R7", "busy low with done", busy_o, 0);
                end
                done_cnt++;
            end
        end
        sclk_prev = sclk_o;
        sdo_prev  = sdo_o;
    end

    task automatic xfer(input bit wide, input int div, input logic [15:0] tx,
                        input logic [15:0] srx, input bit collide);
        exp_t e;
        int   target;
        e.half  = (div < 4) ? 4 : div;
        e.nbits = wide ? 16 : 8;
        e.rx    = wide ? srx : {8'h00, srx[7:0]};
        e.tx    = wide ? tx  : {8'h00, tx[7:0]};
        @(negedge clk);
        exp_q.push_back(e);
        cur_half  = e.half;
        slv_sh    = wide ? srx : {srx[7:0], 8'h00};
        cap       = '0;
        bits_seen = 0;
        busy_run  = 0;
        phase_bad = 0;
        sdo_bad   = 0;
        wide_i    = wide;
        div_i     = div[DIV_W-1:0];
        tx_word_i = tx;
        start_i   = 1'b1;
        target    = done_cnt + 1;
        @(negedge clk);
        start_i = 1'b0;
        chk(busy_o == 1'b1, "R6", "busy after start", busy_o, 1);
        if (collide) begin
            repeat (10) @(negedge clk);
            tx_word_i = ~tx;
            wide_i    = ~wide;
            start_i   = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
            chk(collide_o == 1'b1, "R8", "collision flag set", collide_o, 1);
        end
        while (done_cnt < target) @(negedge clk);
        @(negedge clk);
        chk(done_o == 1'b0, "R7", "done one cycle", done_o, 0);
        chk(rx_word_o == e.rx, "R7", "word held", rx_word_o, e.rx);
        chk(sclk_o == 1'b1 && busy_o == 1'b0, "R9", "idle clock high", sclk_o, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(sclk_o == 1'b1, "R1", "sclk in reset", sclk_o, 1);
        chk(busy_o == 1'b0, "R1", "busy in reset", busy_o, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(sclk_o == 1'b1, "R1", "sclk after reset", sclk_o, 1);
        chk(busy_o == 1'b0, "R1", "busy after reset", busy_o, 0);
        chk(done_o == 1'b0, "R1", "done after reset", done_o, 0);
        chk(collide_o == 1'b0, "R1", "collide after reset", collide_o, 0);
        chk(rx_word_o == 16'h0, "R1", "rx after reset", rx_word_o, 0);

        xfer(1'b1, 0,  16'hA53C, 16'h1F82, 1'b0);
        xfer(1'b0, 3,  16'hFF96, 16'h00C5, 1'b0);
        chk(collide_o == 1'b0, "R8", "no collision yet", collide_o, 0);
        xfer(1'b1, 5,  16'h8001, 16'h7FFE, 1'b1);
        xfer(1'b0, 31, 16'h0081, 16'h003C, 1'b0);
        chk(collide_o == 1'b1, "R8", "collision sticky", collide_o, 1);
        xfer(1'b1, 4,  16'h0000, 16'hFFFF, 1'b0);
        xfer(1'b1, 7,  16'h5A0F, 16'hC3A5, 1'b0);

        repeat (20) @(negedge clk);
        chk(done_cnt == 6, "R8", "done count", done_cnt, 6);
        chk(exp_q.size() == 0, "R8", "scoreboard drained", exp_q.size(), 0);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        fails++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule